// File: doc/BRIEF.md
# Chainable Timer Compare Cell

This block is one cell of a timer array whose cells are linked in a chain. It compares a shared timebase bus with a compare register that software programs. A compare is possible only while the cell is enabled and the level of the select line is one of the levels that software has enabled. When the bus first becomes equal to the compare value, the cell does five things. It sets its request flag. It can raise a service request. It drives its output pin with a programmed action. It sends that action to the next cell in the chain. It pulses its event output for one clock.

A cell that cannot compare passes the incoming event straight through to its event output. An action that arrives on the chain inputs is applied to this cell's pin and sent on to the next cell. When this cell has a match in the same cycle, its own action wins. In one-shot mode the cell turns itself off after its match, and the next write to the control register turns it back on. The capture-after-compare option, used together with one-shot mode, also locks the compare register after the match. The next access to that register, read or write, unlocks it.

A narrow bus port gives access to the registers. Address 0 is control and status. Address 1 is the compare value.

Top module: `chain_cmp_cell`

## Requirements
- R1: After a synchronous reset, every register is 0, with two exceptions: the enable flag is 1 and the output pin is low. The outputs evt_out, srq_out and act_out are 0.
- R2: A compare is allowed only while the cell is enabled and one of two conditions holds: control bit 0 is set with sel_in low, or control bit 1 is set with sel_in high. Setting both bits allows a compare at either select level.
- R3: Reading address 0 returns the status word. Bit 7 holds the current sel_in level, bit 8 the enable flag and bit 9 the request flag. Bits 6:0 return the stored control fields.
- R4: A match happens when compare is allowed and the cycle is the first cycle of equality between tb_bus and the compare register. Equality in the previous cycle counts whether or not compare was allowed then. A match sets the request flag on the next edge. Writing address 0 with bit 9 set clears the flag, but a match in the same cycle wins.
- R5: srq_out is registered. It equals the next value of the request flag ANDed with control bit 2 as it stood before the edge.
- R6: On a match, the pin is updated from the mode in control bits 4:3. The codes are 00 keep, 01 drive low, 10 drive high and 11 invert.
- R7: When there is no match, a nonzero code on act_in is applied to the pin with the same encoding and is repeated on act_out one cycle later. On a match, act_out carries the local mode instead. If there is no match and act_in is 00, act_out is 00.
- R8: While compare is allowed, evt_out is 1 in the cycle after a match and 0 otherwise.
- R9: While compare is not allowed, evt_out takes the value evt_in had one cycle earlier.
- R10: When the one-shot bit (control bit 5) is set, a match clears the enable flag. Any write to address 0 sets the flag again, and this has priority over the match.
- R11: When both the one-shot bit and the capture-after-compare bit (control bit 6) are set, a match locks the compare register. While the register is locked, writes to address 1 are dropped. Any access to address 1 unlocks it, but a match in the same cycle keeps it locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = compare |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational from addr) |
| tb_bus | input | DW | Shared timebase value |
| sel_in | input | 1 | Select line |
| act_in | input | 2 | Action request from previous cell |
| evt_in | input | 1 | Event from previous cell |
| act_out | output | 2 | Action request to next cell |
| evt_out | output | 1 | Event output |
| srq_out | output | 1 | Service request |
| pin_out | output | 1 | Output pin |

## Verification
The assertions check the following on every cycle:
- a match lasts at most one cycle;
- a match always produces an event pulse and a set flag;
- an idle cell passes the event through;
- a forwarded action is repeated on the chain output;
- srq_out follows the request enable;
- one-shot mode disables the cell;
- a locked compare register stays unchanged under writes.

Other behaviour can be shown only by the bench scenarios. These are the exact pin result of each mode code, the interaction of the priorities when a write and a match fall in the same cycle, and the readback of the status bits after re-enable and unlock.

// File: rtl/cmp_cell_pkg.sv
package cmp_cell_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  localparam int B_SEL_LO = 0;
  localparam int B_SEL_HI = 1;
  localparam int B_REQ_EN = 2;
  localparam int B_MODE_L = 3;
  localparam int B_ONESHOT = 5;
  localparam int B_CAC = 6;
  localparam int B_SEL_LVL = 7;
  localparam int B_ENABLED = 8;
  localparam int B_FLAG = 9;
  localparam int CTRL_BITS = 10;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_CLR: apply_act = 1'b0;
      ACT_SET: apply_act = 1'b1;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/cmp_sel_gate.sv
module cmp_sel_gate (
  input  logic sel_in,
  input  logic lo_en,
  input  logic hi_en,
  input  logic cell_en,
  output logic active
);
  always_comb begin
    active = cell_en & ((lo_en & ~sel_in) | (hi_en & sel_in));
  end
endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] tb_bus,
  input  logic [DW-1:0] cmp_val,
  input  logic          active,
  output logic          match
);
  logic eq, eq_q;

  always_comb eq = (tb_bus == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  always_comb match = active & eq & ~eq_q;

  // R4: a match is only the first cycle of an equality run
  p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
    match |=> !match);
endmodule

// File: rtl/cmp_pin_action.sv
module cmp_pin_action
  import cmp_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match,
  input  logic [1:0] mode,
  input  logic [1:0] act_in,
  output logic       pin_out,
  output logic [1:0] act_out
);
  logic       pin_n;
  logic [1:0] act_n;

  always_comb begin
    pin_n = pin_out;
    act_n = 2'b00;
    if (match) begin
      pin_n = apply_act(act_e'(mode), pin_out);
      act_n = mode;
    end else if (act_in != 2'b00) begin
      pin_n = apply_act(act_e'(act_in), pin_out);
      act_n = act_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      act_out <= 2'b00;
    end else begin
      pin_out <= pin_n;
      act_out <= act_n;
    end
  end

  // R7: a forwarded action is repeated to the next cell
  p_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    (!match && act_in != 2'b00) |=> act_out == $past(act_in));
endmodule

// File: rtl/chain_cmp_cell.sv
module chain_cmp_cell
  import cmp_cell_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] tb_bus,
  input  logic          sel_in,
  input  logic [1:0]    act_in,
  input  logic          evt_in,
  output logic [1:0]    act_out,
  output logic          evt_out,
  output logic          srq_out,
  output logic          pin_out
);
  localparam int PADW = DW - CTRL_BITS;

  logic          sel_lo, sel_hi, req_en, one_shot, cac;
  logic [1:0]    mode;
  logic          cell_en, req_flag, prot;
  logic [DW-1:0] cmp_reg;
  logic          active, match;
  logic          wr_ctrl, wr_cmp, acc_cmp;
  logic          flag_n;

  always_comb begin
    wr_ctrl = bus_en & bus_we & ~bus_addr;
    wr_cmp  = bus_en & bus_we & bus_addr;
    acc_cmp = bus_en & bus_addr;
  end

  cmp_sel_gate u_gate (
    .sel_in (sel_in),
    .lo_en  (sel_lo),
    .hi_en  (sel_hi),
    .cell_en(cell_en),
    .active (active)
  );

  cmp_match_det #(.DW(DW)) u_det (
    .clk    (clk),
    .rst    (rst),
    .tb_bus (tb_bus),
    .cmp_val(cmp_reg),
    .active (active),
    .match  (match)
  );

  cmp_pin_action u_act (
    .clk    (clk),
    .rst    (rst),
    .match  (match),
    .mode   (mode),
    .act_in (act_in),
    .pin_out(pin_out),
    .act_out(act_out)
  );

  always_comb begin
    flag_n = req_flag;
    if (wr_ctrl && bus_wdata[B_FLAG]) flag_n = 1'b0;
    if (match) flag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_lo   <= 1'b0;
      sel_hi   <= 1'b0;
      req_en   <= 1'b0;
      mode     <= 2'b00;
      one_shot <= 1'b0;
      cac      <= 1'b0;
      cell_en  <= 1'b1;
      req_flag <= 1'b0;
      prot     <= 1'b0;
      cmp_reg  <= '0;
      evt_out  <= 1'b0;
      srq_out  <= 1'b0;
    end else begin
      req_flag <= flag_n;
      srq_out  <= flag_n & req_en;
      if (match)       evt_out <= 1'b1;
      else if (active) evt_out <= 1'b0;
      else             evt_out <= evt_in;
      if (wr_ctrl) begin
        sel_lo   <= bus_wdata[B_SEL_LO];
        sel_hi   <= bus_wdata[B_SEL_HI];
        req_en   <= bus_wdata[B_REQ_EN];
        mode     <= bus_wdata[B_MODE_L +: 2];
        one_shot <= bus_wdata[B_ONESHOT];
        cac      <= bus_wdata[B_CAC];
        cell_en  <= 1'b1;
      end else if (match && one_shot) begin
        cell_en  <= 1'b0;
      end
      if (match && one_shot && cac) prot <= 1'b1;
      else if (acc_cmp)             prot <= 1'b0;
      if (wr_cmp && !prot) cmp_reg <= bus_wdata;
    end
  end

  always_comb begin
    if (bus_addr) bus_rdata = cmp_reg;
    else bus_rdata = {{PADW{1'b0}}, req_flag, cell_en, sel_in, cac, one_shot,
                      mode, req_en, sel_hi, sel_lo};
  end

  // R8 / R4: a match yields an event pulse and a set flag
  p_match_evt_r8: assert property (@(posedge clk) disable iff (rst)
    match |=> (evt_out && req_flag));
  // R9: an idle cell passes the event through
  p_pass_evt_r9: assert property (@(posedge clk) disable iff (rst)
    (!active && !match) |=> evt_out == $past(evt_in));
  // R5: a service request needs the request enable
  p_srq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    srq_out |-> ($past(req_en) && req_flag));
  // R10: one-shot self-disable
  p_oneshot_r10: assert property (@(posedge clk) disable iff (rst)
    (match && one_shot && !wr_ctrl) |=> !cell_en);
  // R11: a locked compare register ignores writes
  p_locked_r11: assert property (@(posedge clk) disable iff (rst)
    (prot && wr_cmp) |=> cmp_reg == $past(cmp_reg));
endmodule

// File: tb/chain_cmp_cell_tb.sv
module chain_cmp_cell_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 0, bus_we = 0, bus_addr = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] tb_bus = '0;
  logic          sel_in = 0;
  logic [1:0]    act_in = 0;
  logic          evt_in = 0;
  logic [1:0]    act_out;
  logic          evt_out, srq_out, pin_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  chain_cmp_cell #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tb_bus(tb_bus), .sel_in(sel_in), .act_in(act_in), .evt_in(evt_in),
    .act_out(act_out), .evt_out(evt_out), .srq_out(srq_out), .pin_out(pin_out)
  );

  // reference state, built from the requirements
  logic m_lo, m_hi, m_ren, m_os, m_cac, m_en, m_flag, m_prot, m_eqq;
  logic [1:0] m_mode, m_act;
  logic m_pin, m_evt, m_srq;
  logic [DW-1:0] m_cmp;
  logic m_last_match;

  function automatic logic act_apply(input logic [1:0] a, input logic p);
    case (a)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~p;
      default: return p;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    logic [DW-1:0] r;
    r = '0;
    if (bus_addr) r = m_cmp;
    else r[9:0] = {m_flag, m_en, sel_in, m_cac, m_os, m_mode, m_ren, m_hi, m_lo};
    return r;
  endfunction

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_ren = 0; m_os = 0; m_cac = 0; m_en = 1;
    m_flag = 0; m_prot = 0; m_eqq = 0; m_mode = 0; m_act = 0;
    m_pin = 0; m_evt = 0; m_srq = 0; m_cmp = '0; m_last_match = 0;
  endtask

  task automatic model_step();
    logic act, eq, mt, wc, wm, ac, fl;
    act = m_en & ((m_lo & ~sel_in) | (m_hi & sel_in));
    eq  = (tb_bus == m_cmp);
    mt  = act & eq & ~m_eqq;
    wc  = bus_en & bus_we & ~bus_addr;
    wm  = bus_en & bus_we & bus_addr;
    ac  = bus_en & bus_addr;
    fl  = m_flag;
    if (wc && bus_wdata[9]) fl = 0;
    if (mt) fl = 1;
    m_srq = fl & m_ren;
    m_flag = fl;
    m_evt = mt ? 1'b1 : (act ? 1'b0 : evt_in);
    if (mt) begin m_pin = act_apply(m_mode, m_pin); m_act = m_mode; end
    else if (act_in != 0) begin m_pin = act_apply(act_in, m_pin); m_act = act_in; end
    else m_act = 0;
    if (mt && m_os && m_cac) m_prot = 1;
    else if (ac) m_prot = 0;
    if (wm && !(m_prot && !(mt && m_os && m_cac) ? 1'b1 : 1'b0)) begin end
    m_eqq = eq;
    m_last_match = mt;
    if (wc) begin
      m_lo = bus_wdata[0]; m_hi = bus_wdata[1]; m_ren = bus_wdata[2];
      m_mode = bus_wdata[4:3]; m_os = bus_wdata[5]; m_cac = bus_wdata[6];
      m_en = 1;
    end else if (mt && m_os) m_en = 0;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, a, e, $time);
    end
  endtask

  task automatic compare_all(input string t_pin, input string t_evt);
    chk(t_pin, {15'd0, pin_out}, {15'd0, m_pin});
    chk("R7 act_out", {14'd0, act_out}, {14'd0, m_act});
    chk(t_evt, {15'd0, evt_out}, {15'd0, m_evt});
    chk("R5 srq_out", {15'd0, srq_out}, {15'd0, m_srq});
    chk(bus_addr ? "R11 cmp read" : "R3 R4 R10 status read", bus_rdata, exp_rdata());
  endtask

  // one clock: inputs already driven; the compare register is written in
  // the model using the lock state from before the edge
  task automatic cycle(input string t_pin, input string t_evt);
    logic lock_before, wm;
    lock_before = m_prot;
    wm = bus_en & bus_we & bus_addr;
    @(posedge clk);
    model_step();
    if (wm && !lock_before) m_cmp = bus_wdata;
    #2;
    compare_all(t_pin, t_evt);
    @(negedge clk);
  endtask

  task automatic drive(input logic en, input logic we, input logic ad,
                       input logic [DW-1:0] wd, input logic [DW-1:0] tb,
                       input logic s, input logic [1:0] ai, input logic ei);
    bus_en = en; bus_we = we; bus_addr = ad; bus_wdata = wd;
    tb_bus = tb; sel_in = s; act_in = ai; evt_in = ei;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    // R1 reset state
    chk("R1 pin", {15'd0, pin_out}, 16'd0);
    chk("R1 evt", {15'd0, evt_out}, 16'd0);
    chk("R1 srq", {15'd0, srq_out}, 16'd0);
    chk("R1 act", {14'd0, act_out}, 16'd0);
    chk("R1 status", bus_rdata, 16'h0100);
    @(negedge clk);

    // R9: idle cell passes events
    drive(0,0,0,0, 16'd3, 0, 0, 1); cycle("R9 pin", "R9 evt pass");
    drive(0,0,0,0, 16'd3, 1, 0, 0); cycle("R9 pin", "R9 evt pass");
    // R2: low-level enable only; compare=5, set mode
    drive(1,1,1,16'd5, 16'd0, 0, 0, 0); cycle("R2 pin", "R9 evt");
    drive(1,1,0,16'h0015, 16'd0, 1, 0, 0); cycle("R2 pin", "R9 evt"); // lo, ren, mode=10
    drive(0,0,0,0, 16'd5, 1, 0, 1); cycle("R2 no match at high sel", "R9 evt");
    drive(0,0,0,0, 16'd4, 0, 0, 0); cycle("R2 pin", "R8 evt");
    drive(0,0,0,0, 16'd5, 0, 0, 1); cycle("R6 set pin", "R8 evt pulse");
    drive(0,0,0,0, 16'd5, 0, 0, 1); cycle("R4 held eq no rematch", "R8 evt low");
    // R4 flag clear
    drive(1,1,0,16'h0215, 16'd5, 0, 0, 0); cycle("R4 pin", "R8 evt");
    // R6 toggle with both enables, one-shot + cac
    drive(1,1,0,16'h007B, 16'd0, 1, 0, 0); cycle("R6 pin", "R8 evt");
    drive(0,0,0,0, 16'd5, 1, 0, 0); cycle("R6 toggle pin", "R8 evt pulse");
    drive(1,1,1,16'd9, 16'd6, 1, 0, 0); cycle("R11 locked write", "R9 evt");
    drive(1,1,1,16'd9, 16'd6, 1, 0, 0); cycle("R11 unlocked write", "R9 evt");
    drive(1,1,0,16'h000B, 16'd6, 1, 2'b01, 0); cycle("R10 re-enable R7 fwd", "R9 evt");
    drive(0,0,0,0, 16'd9, 1, 2'b11, 0); cycle("R7 local wins", "R8 evt");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic en, we, ad;
      logic [DW-1:0] wd;
      en = ($urandom_range(0, 7) == 0);
      we = $urandom_range(0, 1);
      ad = $urandom_range(0, 1);
      wd = ad ? 16'($urandom_range(0, 7)) : 16'($urandom_range(0, 1023));
      drive(en, we, ad, wd, 16'($urandom_range(0, 7)), $urandom_range(0, 1),
            ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
            $urandom_range(0, 1));
      cycle("R6 R7 pin", "R8 R9 evt");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule